// File: doc/BRIEF.md
# Seconds-Based Watchdog Countdown Timer

This block is a watchdog timer that lives inside a peripheral logical device and is reached through a small indexed register port. Three 8-bit registers sit in that port: a countdown register, a control register and a status register. Software loads a count into the countdown register. A prescaler turns the system clock into a one-second tick, or into a one-minute tick when minute units are selected. The count drops by one on each tick. When the count falls from one to zero, the block pulls its active-low watchdog output low for a fixed number of clocks and latches an expiry flag. If the control register allows it, the same low pulse also goes to a keyboard-reset line.

The counting register is the register software writes. A read returns the time left. Writing zero stops the timer. Writing any nonzero value reloads the count and restarts the prescaler, which makes each rewrite a keepalive. The three register offsets are parameters, so the same block can serve alternate index maps.

Top module: `sec_watchdog`

## Requirements
- R1: After reset the countdown is 0 (timer stopped), control and status read 0x00, and both `wdt_n` and `kbrst_n` are high.
- R2: A nonzero write to the countdown offset loads that value. In second units the count then drops by one every CLK_PER_SEC clocks, counted from the write edge. A read of the countdown offset returns the remaining count.
- R3: On the clock edge where the count goes from 1 to 0, `wdt_n` goes low and stays low for exactly PULSE_CLKS clocks. The count then stays at 0, and no further pulse follows until the register is reloaded.
- R4: Status bit 4 (mask 0x10) is set on expiry. Writing 0 to bit 4 clears it, and writing 1 to it has no effect. Bits 7 and 6 (mask 0xC0) are plain read/write enables, and the other bits read 0. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R5: Writing 0 to the countdown offset stops the timer. No expiry follows and the count reads 0.
- R6: A write to the countdown offset while the timer runs reloads the count and restarts the prescaler, which acts as a keepalive. A write in the same cycle as the final tick wins: the new value is loaded and no expiry occurs.
- R7: Control bit 1 (0x02) sends the expiry pulse to `kbrst_n` as well, with the same timing as `wdt_n`. Control bit 3 (0x08) selects minute units, where one count lasts CLK_PER_SEC*MIN_DIV clocks. Control bits 3..1 read back and the other bits read 0.
- R8: The offsets are parameters, with defaults of 0xF6 for the countdown, 0xF5 for control and 0xF7 for status. A read returns its data with `rd_valid` one clock after `rd_en`. A read of any other offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register offset within the logical device |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High one clock after `rd_en` |
| wdt_n | output | 1 | Active-low watchdog expiry output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse, gated by control bit 1 |

## Verification
Two things can happen in the same cycle: a software write and the final tick that would take the count from 1 to 0. The bench provokes this by loading a count of one and then issuing a write exactly CLK_PER_SEC clocks later, once with a new count and once with a clear of the status flag. A reload must win: `wdt_n` stays high, the new count reads back, and the expiry comes a full period later. A status clear must lose: the pulse fires and the flag reads 0x10.

// File: rtl/sec_wdt_pkg.sv
package sec_wdt_pkg;
  localparam int REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  localparam int CTL_KBRST_BIT  = 1;
  localparam int CTL_MINUTE_BIT = 3;
  localparam int STS_FIRED_BIT  = 4;

  localparam reg_t CTL_MASK      = 8'h0E;
  localparam reg_t STS_KEEP_MASK = 8'hC0;
  localparam reg_t STS_FIRED     = 8'h10;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int CLK_PER_SEC = 125_000_000,
  parameter int MIN_DIV     = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic minute_mode,
  output logic unit_tick
);
  localparam int PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;

  logic [PW-1:0] pre_q;
  logic          sec_tick;

  assign sec_tick = (pre_q == PW'(CLK_PER_SEC - 1));

  always_ff @(posedge clk) begin
    if (rst || restart)  pre_q <= '0;
    else if (sec_tick)   pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  generate
    if (MIN_DIV > 1) begin : g_min
      localparam int MW = $clog2(MIN_DIV);
      logic [MW-1:0] min_q;
      logic          min_last;
      assign min_last = (min_q == MW'(MIN_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || restart) min_q <= '0;
        else if (sec_tick)  min_q <= min_last ? '0 : min_q + 1'b1;
      end
      assign unit_tick = sec_tick && (!minute_mode || min_last);
    end else begin : g_nomin
      assign unit_tick = sec_tick;
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import sec_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  reg_t load_val,
  input  logic tick,
  output reg_t count_q,
  output logic fire
);
  assign fire = tick && (count_q == reg_t'(1)) && !load;

  always_ff @(posedge clk) begin
    if (rst)                          count_q <= '0;
    else if (load)                    count_q <= load_val;
    else if (tick && count_q != '0)   count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import sec_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic sts_we,
  input  reg_t wr_data,
  input  logic fire,
  output reg_t ctl_q,
  output reg_t sts_q
);
  logic fired_d;

  always_comb begin
    if (fire)                                  fired_d = 1'b1;
    else if (sts_we && !wr_data[STS_FIRED_BIT]) fired_d = 1'b0;
    else                                       fired_d = sts_q[STS_FIRED_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= wr_data & CTL_MASK;
      sts_q <= ((sts_we ? wr_data : sts_q) & STS_KEEP_MASK) |
               (fired_d ? STS_FIRED : reg_t'(0));
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic route_kb,
  output logic wdt_n,
  output logic kbrst_n
);
  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      wdt_n   <= 1'b1;
      kbrst_n <= 1'b1;
    end else if (fire) begin
      left_q  <= CW'(PULSE_CLKS);
      wdt_n   <= 1'b0;
      kbrst_n <= !route_kb;
    end else if (left_q > CW'(1)) begin
      left_q  <= left_q - 1'b1;
    end else if (left_q == CW'(1)) begin
      left_q  <= '0;
      wdt_n   <= 1'b1;
      kbrst_n <= 1'b1;
    end
  end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import sec_wdt_pkg::*;
#(
  parameter int          CLK_PER_SEC = 125_000_000,
  parameter int          MIN_DIV     = 60,
  parameter int          PULSE_CLKS  = 16,
  parameter logic [7:0]  OFF_TMR     = 8'hF6,
  parameter logic [7:0]  OFF_CTL     = 8'hF5,
  parameter logic [7:0]  OFF_STS     = 8'hF7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       wdt_n,
  output logic       kbrst_n
);
  logic tmr_we, ctl_we, sts_we;
  logic unit_tick, fire;
  reg_t count_q, ctl_q, sts_q;

  assign tmr_we = wr_en && (addr == OFF_TMR);
  assign ctl_we = wr_en && (addr == OFF_CTL);
  assign sts_we = wr_en && (addr == OFF_STS);

  wdt_tick_gen #(.CLK_PER_SEC(CLK_PER_SEC), .MIN_DIV(MIN_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(tmr_we),
    .minute_mode(ctl_q[CTL_MINUTE_BIT]), .unit_tick(unit_tick)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst(rst), .load(tmr_we), .load_val(wr_data),
    .tick(unit_tick), .count_q(count_q), .fire(fire)
  );

  wdt_regs u_regs (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .sts_we(sts_we),
    .wr_data(wr_data), .fire(fire), .ctl_q(ctl_q), .sts_q(sts_q)
  );

  wdt_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .route_kb(ctl_q[CTL_KBRST_BIT]),
    .wdt_n(wdt_n), .kbrst_n(kbrst_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (addr == OFF_TMR)      rd_data <= count_q;
        else if (addr == OFF_CTL) rd_data <= ctl_q;
        else if (addr == OFF_STS) rd_data <= sts_q;
        else                      rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/sec_wdt_check.sv
module sec_wdt_check #(
  parameter int PULSE_CLKS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       tmr_we,
  input logic [7:0] wr_data,
  input logic [7:0] count,
  input logic       tick,
  input logic       wdt_n,
  input logic       kbrst_n,
  input logic       fired
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)         low_run <= 0;
    else if (!wdt_n) low_run <= low_run + 1;
    else             low_run <= 0;
  end

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!tmr_we && count == 8'd0) |=> (count == 8'd0));

  a_r2_never_climbs: assert property (@(posedge clk) disable iff (rst)
    !tmr_we |=> (count <= $past(count)));

  a_r6_write_loads: assert property (@(posedge clk) disable iff (rst)
    tmr_we |=> (count == $past(wr_data)));

  // R3 and R4: expiry drives the output low and sets the flag
  a_r3_expiry_fires: assert property (@(posedge clk) disable iff (rst)
    (tick && count == 8'd1 && !tmr_we) |=> (!wdt_n && fired));

  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    low_run <= PULSE_CLKS);

  a_r7_kb_within_pulse: assert property (@(posedge clk) disable iff (rst)
    !kbrst_n |-> !wdt_n);
endmodule

bind sec_watchdog sec_wdt_check #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .rst(rst), .tmr_we(tmr_we), .wr_data(wr_data),
  .count(count_q), .tick(unit_tick), .wdt_n(wdt_n), .kbrst_n(kbrst_n),
  .fired(sts_q[4])
);

// File: tb/sec_watchdog_bench.sv
module sec_watchdog_bench;
  localparam int N  = 10;
  localparam int MD = 4;
  localparam int P  = 5;
  localparam logic [7:0] A_TMR = 8'hF6;
  localparam logic [7:0] A_CTL = 8'hF5;
  localparam logic [7:0] A_STS = 8'hF7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, wdt_n, kbrst_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  sec_watchdog #(.CLK_PER_SEC(N), .MIN_DIV(MD), .PULSE_CLKS(P)) u_sec_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .wdt_n(wdt_n), .kbrst_n(kbrst_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results come out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected rd_valid", 8'h01, 8'h00);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
  end

  // All tasks start and end just after a negative edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wt(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 wdt_n after reset", {7'd0, wdt_n}, 8'h01);
    chk("R1 kbrst_n after reset", {7'd0, kbrst_n}, 8'h01);
    rd(A_TMR, 8'h00, "R1 count after reset");
    rd(A_CTL, 8'h00, "R1 ctrl after reset");
    rd(A_STS, 8'h00, "R1 status after reset");
    rd(8'h00, 8'h00, "R8 unmapped offset");

    // R2/R3: load 2 seconds, expiry at write edge + 2N
    wr(A_TMR, 8'd2);
    wt(2*N - 1);
    chk("R2 no expiry before 2N", {7'd0, wdt_n}, 8'h01);
    wt(1);
    chk("R3 wdt_n low at expiry", {7'd0, wdt_n}, 8'h00);
    chk("R7 kbrst_n idle with bit1 clear", {7'd0, kbrst_n}, 8'h01);
    wt(P - 1);
    chk("R3 still low at end of pulse", {7'd0, wdt_n}, 8'h00);
    wt(1);
    chk("R3 high after PULSE_CLKS", {7'd0, wdt_n}, 8'h01);
    rd(A_STS, 8'h10, "R4 flag set by expiry");
    wt(3*N);
    chk("R3 no second pulse", {7'd0, wdt_n}, 8'h01);
    rd(A_TMR, 8'h00, "R3 count holds at 0");

    // R4 status field behaviour
    wr(A_STS, 8'h00);
    rd(A_STS, 8'h00, "R4 clear flag");
    wr(A_STS, 8'hFF);
    rd(A_STS, 8'hC0, "R4 write 1 to flag ignored, enables kept");
    wr(A_STS, 8'h00);
    rd(A_STS, 8'h00, "R4 enables cleared");

    // R2 remaining count, then R5 stop
    wr(A_TMR, 8'd5);
    wt(2*N + 4);
    rd(A_TMR, 8'd3, "R2 remaining count");
    wr(A_TMR, 8'd0);
    wt(6*N);
    chk("R5 stopped no expiry", {7'd0, wdt_n}, 8'h01);
    rd(A_TMR, 8'h00, "R5 count reads 0");
    rd(A_STS, 8'h00, "R5 flag untouched");

    // R6 keepalive
    wr(A_TMR, 8'd2);
    wt(15);
    wr(A_TMR, 8'd2);
    wt(2*N - 1);
    chk("R6 keepalive postponed expiry", {7'd0, wdt_n}, 8'h01);
    wt(1);
    chk("R6 expiry after reload period", {7'd0, wdt_n}, 8'h00);
    wt(2*P);

    // R6 collision: reload on the final tick
    wr(A_STS, 8'h00);
    wr(A_TMR, 8'd1);
    wt(N - 1);
    wr(A_TMR, 8'd4);
    chk("R6 reload beats final tick", {7'd0, wdt_n}, 8'h01);
    rd(A_TMR, 8'd4, "R6 reloaded value");
    rd(A_STS, 8'h00, "R6 no flag on collision");
    wt(4*N - 3);
    chk("R6 new period not yet over", {7'd0, wdt_n}, 8'h01);
    wt(1);
    chk("R6 expiry after new period", {7'd0, wdt_n}, 8'h00);
    wt(2*P);

    // R4 collision: clearing write on the expiry edge
    wr(A_STS, 8'h00);
    rd(A_STS, 8'h00, "R4 pre-clear");
    wr(A_TMR, 8'd1);
    wt(N - 1);
    wr(A_STS, 8'h00);
    chk("R3 expiry on collision edge", {7'd0, wdt_n}, 8'h00);
    rd(A_STS, 8'h10, "R4 set wins over clear");
    wt(2*P);

    // R7 control readback and keyboard routing
    wr(A_CTL, 8'hFF);
    rd(A_CTL, 8'h0E, "R7 ctrl readback mask");
    wr(A_CTL, 8'h02);
    rd(A_CTL, 8'h02, "R7 ctrl kb bit");
    wr(A_TMR, 8'd1);
    wt(N - 1);
    chk("R7 kbrst_n high before expiry", {7'd0, kbrst_n}, 8'h01);
    wt(1);
    chk("R7 kbrst_n low at expiry", {7'd0, kbrst_n}, 8'h00);
    chk("R7 wdt_n low with kb pulse", {7'd0, wdt_n}, 8'h00);
    wt(P);
    chk("R7 kbrst_n released", {7'd0, kbrst_n}, 8'h01);

    // R7 minute units
    wr(A_CTL, 8'h08);
    wr(A_TMR, 8'd1);
    wt(N*MD - 1);
    chk("R7 minute mode not yet", {7'd0, wdt_n}, 8'h01);
    wt(1);
    chk("R7 minute mode expiry", {7'd0, wdt_n}, 8'h00);
    chk("R7 kbrst_n idle in minute test", {7'd0, kbrst_n}, 8'h01);
    wt(2*P);
    wt(2);
    chk("R8 all reads answered", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule